// File: doc/BRIEF.md
# Parallel FIR Bank with Arithmetic Error Correction

This block runs four FIR filters side by side. Each filter has its own stream of signed samples, and all four use the same coefficient set. Three extra filters guard the four data filters. Each extra filter is fed the sum of three of the data streams. Because the filters are linear, the output of each check filter must equal the sum of the matching three data-filter outputs.

Each time a filtered sample is produced, the block compares the three checks and forms a 3-bit syndrome. The syndrome points at one faulty data filter or at one faulty check filter. If a data filter is at fault, its output is rebuilt from a check output and two healthy data outputs. The final choice between the rebuilt value and the raw value is made three times, and a bitwise majority vote resolves the three copies.

A fault-injection port flips chosen bits in any one of the seven filter outputs. This lets the correction path be exercised in place.

Top module: `ecc_fir_bank`

## Requirements
- R1: While reset is held and straight after it, out_valid, syndrome, err_flag and all four out_y words are zero, and every delay line is cleared.
- R2: With no injected fault, out_y[i] equals the sum over tap k of COEFS[k] times the k-th most recent accepted sample of in_samples[i], where tap 0 is the newest sample and the result is sign-extended to ACC_W bits.
- R3: Each sample accepted with in_valid high yields exactly one out_valid pulse, two clock edges later; no out_valid appears without an accepted sample.
- R4: The syndrome bits map to the checks as follows: bit 2 compares check A (streams 0,1,2), bit 1 compares check B (streams 0,1,3) and bit 0 compares check C (streams 0,2,3). A bit is set when the magnitude of the difference exceeds THRESH (default 0), and err_flag is high exactly when the syndrome is nonzero.
- R5: Syndrome 111 rebuilds stream 0, 110 rebuilds stream 1, 101 rebuilds stream 2 and 011 rebuilds stream 3. With one faulted data filter, all four out_y words equal their fault-free values.
- R6: A syndrome with exactly one bit set (a check filter at fault) passes all four data outputs through unchanged.
- R7: When inj_en is high, inj_mask is XORed onto the output of the filter picked by inj_sel: 0 to 3 pick data streams 0 to 3, and 4, 5 and 6 pick checks A, B and C. inj_sel of 7 or a zero mask has no effect. The injection acts on a sample in the cycle after that sample is accepted.
- R8: Cycles with in_valid low advance no delay line and change no output, so gaps in a stream do not alter its filtered values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Samples on in_samples are accepted this cycle |
| in_samples | input | 4*IN_W | Four signed samples; slice i is stream i |
| inj_en | input | 1 | Enable fault injection |
| inj_sel | input | 3 | Filter picked for injection (0-3 data, 4-6 checks A-C) |
| inj_mask | input | ACC_W | Bits to flip in the picked filter output |
| out_valid | output | 1 | Corrected outputs are valid |
| out_y | output | 4*ACC_W | Four corrected signed outputs; slice i is stream i |
| syndrome | output | 3 | Check results {A,B,C} for the current output |
| err_flag | output | 1 | Syndrome is nonzero |

## Verification
The in-line properties assume that injection is the only source of error and that it touches at most one filter per output. They also assume THRESH is zero, so that any nonzero mask must be detected and the restored value must match the clean filter output bit for bit. The stimulus respects this: it holds each injection setting for exactly the one cycle in which the targeted sample sits in the filter output registers. It then moves through every filter index, single-bit and wide masks, the extreme sample values, idle gaps between samples, and injections that the design must ignore.

// File: rtl/ecc_fir_pkg.sv
package ecc_fir_pkg;

  // Syndrome codes {A,B,C} that point at a data stream
  localparam logic [2:0] SYN_D0 = 3'b111;
  localparam logic [2:0] SYN_D1 = 3'b110;
  localparam logic [2:0] SYN_D2 = 3'b101;
  localparam logic [2:0] SYN_D3 = 3'b011;

  // One-hot over data streams of the stream to rebuild; zero otherwise
  function automatic logic [3:0] data_fault(input logic [2:0] syn);
    case (syn)
      SYN_D0:  return 4'b0001;
      SYN_D1:  return 4'b0010;
      SYN_D2:  return 4'b0100;
      SYN_D3:  return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  // Exactly one check disagrees: the check filter itself is at fault
  function automatic logic check_only(input logic [2:0] syn);
    return (syn == 3'b001) || (syn == 3'b010) || (syn == 3'b100);
  endfunction

endpackage

// File: rtl/ecc_fir_lane.sv
module ecc_fir_lane #(
  parameter int W_IN   = 10,
  parameter int W_ACC  = 21,
  parameter int NTAPS  = 8,
  parameter int COEF_W = 8,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    vld_i,
  input  logic signed [W_IN-1:0]  x_i,
  output logic signed [W_ACC-1:0] y_o,
  output logic                    vld_o
);

  logic [NTAPS-2:0][W_IN-1:0] hist;
  logic signed [W_ACC-1:0]    acc;

  function automatic logic signed [W_ACC-1:0] mac(
    input logic signed [W_IN-1:0]  newest,
    input logic [NTAPS-2:0][W_IN-1:0] past
  );
    logic signed [W_ACC-1:0] sum;
    sum = W_ACC'(newest) * W_ACC'($signed(COEFS[COEF_W-1:0]));
    for (int k = 1; k < NTAPS; k++) begin
      sum = sum + W_ACC'($signed(past[k-1])) *
                  W_ACC'($signed(COEFS[k*COEF_W +: COEF_W]));
    end
    return sum;
  endfunction

  always_comb acc = mac(x_i, hist);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist  <= '0;
      y_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        hist <= {hist[NTAPS-3:0], x_i};
        y_o  <= acc;
      end
    end
  end

  // R8: no accepted sample, no change of the filter output
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(y_o));

endmodule

// File: rtl/ecc_fir_fix.sv
module ecc_fir_fix
  import ecc_fir_pkg::*;
#(
  parameter int W      = 21,
  parameter int THRESH = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vld_i,
  input  logic [3:0][W-1:0]   y_i,
  input  logic [2:0][W-1:0]   z_i,
  output logic [3:0][W-1:0]   y_o,
  output logic                vld_o,
  output logic [2:0]          syn_o,
  output logic                err_o
);

  localparam int DW = W + 2;

  logic signed [DW-1:0] diff_a, diff_b, diff_c;
  logic [2:0]           syn;
  logic [3:0][W-1:0]    rebuilt;
  logic [2:0][3:0][W-1:0] cand;
  logic [4*W-1:0]       voted;

  function automatic logic signed [DW-1:0] ext(input logic [W-1:0] v);
    return DW'($signed(v));
  endfunction

  function automatic logic over(input logic signed [DW-1:0] d);
    logic signed [DW-1:0] mag;
    mag = (d < 0) ? -d : d;
    return mag > $signed(DW'(THRESH));
  endfunction

  // Each check has its own adder chain; no partial sum is shared
  always_comb begin
    diff_a = ext(z_i[0]) - (ext(y_i[0]) + ext(y_i[1]) + ext(y_i[2]));
    diff_b = ext(z_i[1]) - (ext(y_i[0]) + ext(y_i[1]) + ext(y_i[3]));
    diff_c = ext(z_i[2]) - (ext(y_i[0]) + ext(y_i[2]) + ext(y_i[3]));
    syn    = {over(diff_a), over(diff_b), over(diff_c)};
  end

  always_comb begin
    rebuilt[0] = z_i[0] - y_i[1] - y_i[2];
    rebuilt[1] = z_i[0] - y_i[0] - y_i[2];
    rebuilt[2] = z_i[0] - y_i[0] - y_i[1];
    rebuilt[3] = z_i[1] - y_i[0] - y_i[1];
  end

  // Three copies of the selection, resolved by bitwise majority
  for (genvar r = 0; r < 3; r++) begin : g_sel
    logic [3:0] pick;
    always_comb begin
      pick = data_fault(syn);
      for (int i = 0; i < 4; i++) begin
        cand[r][i] = pick[i] ? rebuilt[i] : y_i[i];
      end
    end
  end

  always_comb voted = (cand[0] & cand[1]) | (cand[0] & cand[2]) | (cand[1] & cand[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_o   <= '0;
      vld_o <= 1'b0;
      syn_o <= '0;
      err_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        y_o   <= voted;
        syn_o <= syn;
        err_o <= |syn;
      end
    end
  end

  // R3: one output strobe per filtered sample, one cycle later
  a_r3_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);
  // R6: a lone check disagreement leaves the data outputs untouched
  a_r6_check_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && check_only(syn)) |=> (y_o == $past(y_i)));

endmodule

// File: rtl/ecc_fir_bank.sv
module ecc_fir_bank #(
  parameter int IN_W   = 8,
  parameter int COEF_W = 8,
  parameter int NTAPS  = 8,
  parameter logic [NTAPS*COEF_W-1:0] COEFS =
    {8'shFE, 8'sh07, 8'shF4, 8'sh26, 8'sh40, 8'sh11, 8'shF7, 8'sh05},
  parameter int THRESH = 0,
  parameter int ACC_W  = IN_W + 2 + COEF_W + $clog2(NTAPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [3:0][IN_W-1:0]  in_samples,
  input  logic                  inj_en,
  input  logic [2:0]            inj_sel,
  input  logic [ACC_W-1:0]      inj_mask,
  output logic                  out_valid,
  output logic [3:0][ACC_W-1:0] out_y,
  output logic [2:0]            syndrome,
  output logic                  err_flag
);

  localparam int SUM_W  = IN_W + 2;
  localparam int NLANES = 7;

  logic [NLANES-1:0][SUM_W-1:0] lane_in;
  logic [NLANES-1:0][ACC_W-1:0] lane_clean;
  logic [NLANES-1:0][ACC_W-1:0] lane_hit;
  logic [NLANES-1:0]            lane_vld;
  logic                         filt_vld;

  function automatic logic [SUM_W-1:0] add3(
    input logic [IN_W-1:0] a, input logic [IN_W-1:0] b, input logic [IN_W-1:0] c);
    return SUM_W'($signed(a)) + SUM_W'($signed(b)) + SUM_W'($signed(c));
  endfunction

  // Encoder: data lanes take the widened sample, checks take their own sums
  for (genvar d = 0; d < 4; d++) begin : g_data_in
    assign lane_in[d] = SUM_W'($signed(in_samples[d]));
  end
  assign lane_in[4] = add3(in_samples[0], in_samples[1], in_samples[2]);
  assign lane_in[5] = add3(in_samples[0], in_samples[1], in_samples[3]);
  assign lane_in[6] = add3(in_samples[0], in_samples[2], in_samples[3]);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic signed [ACC_W-1:0] y_raw;
    ecc_fir_lane #(
      .W_IN(SUM_W), .W_ACC(ACC_W), .NTAPS(NTAPS), .COEF_W(COEF_W), .COEFS(COEFS)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .vld_i(in_valid),
      .x_i($signed(lane_in[g])), .y_o(y_raw), .vld_o(lane_vld[g])
    );
    assign lane_clean[g] = y_raw;
    assign lane_hit[g]   = lane_clean[g] ^
                           ((inj_en && (inj_sel == 3'(g))) ? inj_mask : '0);
  end

  assign filt_vld = lane_vld[0];

  ecc_fir_fix #(.W(ACC_W), .THRESH(THRESH)) u_fix (
    .clk(clk), .rst_n(rst_n), .vld_i(filt_vld),
    .y_i(lane_hit[3:0]), .z_i(lane_hit[6:4]),
    .y_o(out_y), .vld_o(out_valid), .syn_o(syndrome), .err_o(err_flag)
  );

  // R3: all seven lanes produce their results in the same cycle
  a_r3_lanes_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    filt_vld |-> (&lane_vld));
  // R4: without injection every check agrees
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_vld && !inj_en) |=> (syndrome == 3'b000));
  // R5: a single data-lane fault is fully repaired at the outputs
  a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_vld && inj_en && !inj_sel[2] && (THRESH == 0))
      |=> (out_y == $past(lane_clean[3:0])));

endmodule

// File: tb/ecc_fir_bank_tb.sv
module ecc_fir_bank_tb;

  localparam int CLK_P  = 10;
  localparam int IN_W   = 8;
  localparam int COEF_W = 8;
  localparam int NTAPS  = 8;
  localparam logic [NTAPS*COEF_W-1:0] COEFS =
    {8'shFE, 8'sh07, 8'shF4, 8'sh26, 8'sh40, 8'sh11, 8'shF7, 8'sh05};
  localparam int ACC_W  = IN_W + 2 + COEF_W + $clog2(NTAPS);

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic [3:0][IN_W-1:0]  in_samples = '0;
  logic                  inj_en = 1'b0;
  logic [2:0]            inj_sel = '0;
  logic [ACC_W-1:0]      inj_mask = '0;
  logic                  out_valid;
  logic [3:0][ACC_W-1:0] out_y;
  logic [2:0]            syndrome;
  logic                  err_flag;

  ecc_fir_bank #(.IN_W(IN_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .COEFS(COEFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .inj_en(inj_en), .inj_sel(inj_sel), .inj_mask(inj_mask),
    .out_valid(out_valid), .out_y(out_y), .syndrome(syndrome), .err_flag(err_flag)
  );

  typedef struct packed {
    logic signed [3:0][63:0] y;
    logic [2:0]              syn;
    logic [31:0]             cyc;
  } exp_t;

  exp_t   exp_q[$];
  string  tag_q[$];
  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  int     seen   = 0;
  int     pushed = 0;
  bit     done   = 0;
  longint hist [4][NTAPS];
  bit               p_ie   = 0;
  logic [2:0]       p_sel  = '0;
  logic [ACC_W-1:0] p_mask = '0;

  initial forever #(CLK_P/2) clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [2:0] exp_syn(input bit ie, input logic [2:0] sel,
                                         input logic [ACC_W-1:0] mask);
    if (!ie || mask == '0) return 3'b000;
    case (sel)
      3'd0: return 3'b111;
      3'd1: return 3'b110;
      3'd2: return 3'b101;
      3'd3: return 3'b011;
      3'd4: return 3'b100;
      3'd5: return 3'b010;
      3'd6: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  // Driver: one call per cycle; injection of an item lands one cycle later (R7)
  task automatic push(input bit v, input int s0, input int s1, input int s2, input int s3,
                      input bit ie, input logic [2:0] sel, input logic [ACC_W-1:0] mask);
    int   s[4];
    exp_t e;
    string tag;
    s = '{s0, s1, s2, s3};
    @(negedge clk);
    in_valid = v;
    for (int i = 0; i < 4; i++) in_samples[i] = IN_W'(s[i]);
    inj_en = p_ie; inj_sel = p_sel; inj_mask = p_mask;
    p_ie = ie; p_sel = sel; p_mask = mask;
    if (v) begin
      for (int i = 0; i < 4; i++) begin
        longint acc = 0;
        for (int k = NTAPS-1; k > 0; k--) hist[i][k] = hist[i][k-1];
        hist[i][0] = s[i];
        for (int k = 0; k < NTAPS; k++)
          acc += hist[i][k] * longint'($signed(COEFS[k*COEF_W +: COEF_W]));
        e.y[i] = acc;
      end
      e.syn = exp_syn(ie, sel, mask);
      e.cyc = 32'(cyc + 2);
      if (e.syn == 3'b000)         tag = "R2";
      else if ($countones(e.syn) == 1) tag = "R6";
      else                         tag = "R5";
      if (ie && e.syn == 3'b000)   tag = "R7";
      exp_q.push_back(e);
      tag_q.push_back(tag);
      pushed++;
    end
  endtask

  // Monitor: pops one expected item for every output strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        seen++;
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected out_valid", 1, 0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(32'(cyc) == e.cyc, "R3 latency", cyc, e.cyc);
          for (int i = 0; i < 4; i++)
            check(longint'($signed(out_y[i])) == e.y[i], {t, " out_y"},
                  longint'($signed(out_y[i])), e.y[i]);
          check(syndrome == e.syn, "R4 syndrome", syndrome, e.syn);
          check(err_flag == (e.syn != 3'b000), "R4 err_flag", err_flag, e.syn != 3'b000);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ACC_W-1:0] masks[3];
    masks = '{ACC_W'(1), ACC_W'(1) << (ACC_W-1), ACC_W'(21'h15A5A)};
    for (int i = 0; i < 4; i++) for (int k = 0; k < NTAPS; k++) hist[i][k] = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(syndrome == 3'b000, "R1 syndrome", syndrome, 0);
    check(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
    check(out_y == '0, "R1 out_y", 1, 0);
    rst_n = 1'b1;

    // R2: clean mixed streams
    for (int n = 0; n < 16; n++)
      push(1, ((n*37) % 256) - 128, ((n*53 + 11) % 256) - 128,
           (n % 2) ? 127 : -128, n - 8, 0, 3'd0, '0);
    // R2: extreme values on all streams
    for (int n = 0; n < 8; n++) push(1, 127, 127, 127, 127, 0, 3'd0, '0);
    for (int n = 0; n < 8; n++) push(1, -128, -128, -128, -128, 0, 3'd0, '0);

    // R5 and R6: every lane with several masks, back to back
    for (int g = 0; g < 7; g++)
      for (int m = 0; m < 3; m++)
        push(1, g*19 - 60, 90 - m*30, -g*7, (g*m*13) % 120, 1, 3'(g), masks[m]);

    // R7: out-of-range selector and zero mask change nothing
    push(1, 5, -6, 7, -8, 1, 3'd7, masks[2]);
    push(1, 100, -100, 50, -50, 1, 3'd2, '0);
    push(1, -1, 2, -3, 4, 0, 3'd0, '0);

    // R8: idle gaps, including injection aimed at idle cycles
    for (int n = 0; n < 10; n++) begin
      push(1, n*9 - 40, 30 - n*4, (n*n) % 100, -n*11, n % 3 == 0, 3'(n % 4), masks[n % 3]);
      push(0, 99, 99, 99, 99, 1, 3'(n % 7), masks[1]);
      push(0, -77, -77, -77, -77, 0, 3'd0, '0);
    end
    push(1, 12, 34, 56, 78, 1, 3'd3, masks[0]);

    for (int n = 0; n < 6; n++) push(0, 0, 0, 0, 0, 0, 3'd0, '0);
    @(negedge clk);
    // R3: every accepted sample produced exactly one output
    check(exp_q.size() == 0, "R3 pending items", exp_q.size(), 0);
    check(seen == pushed, "R3 output count", seen, pushed);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule